// File: doc/BRIEF.md
# FIFO Misuse Error Status Register

This block watches a group of internal FIFOs and records every misuse in one 32-bit sticky status word. For each monitored FIFO it receives the write pulse, the read pulse, the full flag and the empty flag. Three kinds of fault are recognised:

- a write pulse while the FIFO reports full;
- a read pulse while the FIFO reports empty;
- the illegal state in which a FIFO reports full and empty at once.

A fault on FIFO *i* sets source bit *i*. In the same cycle it also sets the shared type bit that names the kind of fault.

Software reads the status word and clears bits by writing a mask. A zero in the written data clears the matching bit, and a one leaves it unchanged. A fault that arrives in the same cycle as the write wins over the clear. The block also drives a FIFO-error interrupt. The interrupt stays high while any source bit is set, so software can clear the word to acknowledge it.

The FIFOs themselves are outside the block; it only observes their status signals.

Top module: `fifo_fault_status`

## Requirements
- R1: After reset `err_code_o` reads 0 and `irq_fifo_err_o` is low.
- R2: A write pulse on FIFO i while its full flag is high sets bit i and bit 28 (write-when-full type) of `err_code_o`, visible one clock after the cycle of the pulse.
- R3: A read pulse on FIFO i while its empty flag is high sets bit i and bit 29 (read-when-empty type), visible one clock later.
- R4: Full and empty high together on FIFO i, with or without pulses, sets bit i and bit 30 (full-and-empty type), visible one clock later.
- R5: Legal activity sets nothing. This covers writes while not full, reads while not empty, and full or empty flags without the matching pulse.
- R6: Every set bit stays set after its cause goes away, until software clears it.
- R7: A software write (`sw_wr_i` high for one cycle) clears each bit of bits 0..15 and 28..30 whose written data bit is 0. Bits whose written data bit is 1 keep their value. The result is visible one clock later.
- R8: When a fault and a software clear of the same bits occur in the same cycle, the bits set by the fault end up set.
- R9: Faults on several FIFOs in the same cycle set all of their source bits and all of the matching type bits together.
- R10: Bits 16..27 and bit 31 of `err_code_o` always read 0, even after software writes ones to them.
- R11: `irq_fifo_err_o` is high exactly while at least one source bit (0..15) is set. It rises one clock after the faulting cycle and falls one clock after the write that clears the last source bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| fifo_wr_i | input | 16 | Write pulse of each monitored FIFO |
| fifo_rd_i | input | 16 | Read pulse of each monitored FIFO |
| fifo_full_i | input | 16 | Full flag of each monitored FIFO |
| fifo_empty_i | input | 16 | Empty flag of each monitored FIFO |
| sw_wr_i | input | 1 | Software write strobe to the status word |
| sw_wdata_i | input | 32 | Software write data; a 0 clears the matching bit |
| err_code_o | output | 32 | Sticky error status word |
| irq_fifo_err_o | output | 1 | FIFO-error interrupt, level |

## Verification
The bench builds the block with its default parameters:

- sixteen sources;
- the type field at bit 28.

These defaults put the lowest source (bit 0) and the highest source (bit 15) under test. Bit 15 sits right next to the reserved range, so a stray set there would show up as reserved bits reading non-zero. The default type position also places the three type bits between reserved bits 16..27 and reserved bit 31, so a write of all ones checks that the field mapping leaks into neither reserved range.

// File: rtl/fifo_fault_pkg.sv
package fifo_fault_pkg;
  // Kinds of FIFO misuse; the value is the offset inside the type field.
  typedef enum logic [1:0] {
    KIND_WR_FULL    = 2'd0,
    KIND_RD_EMPTY   = 2'd1,
    KIND_FULL_EMPTY = 2'd2
  } fault_kind_e;

  localparam int unsigned NUM_KINDS   = 3;
  localparam int unsigned STS_W       = 32;
  localparam int unsigned DEF_SRC     = 16;
  localparam int unsigned DEF_KIND_LSB = 28;
endpackage

// File: rtl/fifo_fault_detect.sv
module fifo_fault_detect
  import fifo_fault_pkg::*;
#(
  parameter int unsigned NUM_SRC = DEF_SRC
) (
  input  logic [NUM_SRC-1:0]   wr_i,
  input  logic [NUM_SRC-1:0]   rd_i,
  input  logic [NUM_SRC-1:0]   full_i,
  input  logic [NUM_SRC-1:0]   empty_i,
  output logic [NUM_SRC-1:0]   src_hit_o,
  output logic [NUM_KINDS-1:0] kind_hit_o
);
  logic [NUM_SRC-1:0] ovf;
  logic [NUM_SRC-1:0] unf;
  logic [NUM_SRC-1:0] bad;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign ovf[i]       = wr_i[i] & full_i[i];
    assign unf[i]       = rd_i[i] & empty_i[i];
    assign bad[i]       = full_i[i] & empty_i[i];
    assign src_hit_o[i] = ovf[i] | unf[i] | bad[i];
  end

  always_comb begin
    kind_hit_o                       = '0;
    kind_hit_o[int'(KIND_WR_FULL)]    = |ovf;
    kind_hit_o[int'(KIND_RD_EMPTY)]   = |unf;
    kind_hit_o[int'(KIND_FULL_EMPTY)] = |bad;
  end
endmodule

// File: rtl/fault_sticky_bank.sv
module fault_sticky_bank #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic             clr_en_i,
  input  logic [WIDTH-1:0] keep_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_d;
  logic [WIDTH-1:0] clr_mask;
  logic             upd_en;

  // Next state: new faults take priority over the software clear.
  always_comb begin
    clr_mask = clr_en_i ? ~keep_i : '0;
    q_d      = set_i | (q_o & ~clr_mask);
    upd_en   = clr_en_i | (|set_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= '0;
    else if (upd_en) q_o <= q_d;
  end

  // R8: a bit being set this cycle is set next cycle regardless of clear
  assert_set_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));

  // R7: a clear with no new fault leaves exactly the kept bits
  assert_clear_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en_i && set_i == '0) |=> (q_o == ($past(q_o) & $past(keep_i))));
endmodule

// File: rtl/fifo_fault_status.sv
module fifo_fault_status
  import fifo_fault_pkg::*;
#(
  parameter int unsigned NUM_SRC  = DEF_SRC,
  parameter int unsigned KIND_LSB = DEF_KIND_LSB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] fifo_wr_i,
  input  logic [NUM_SRC-1:0] fifo_rd_i,
  input  logic [NUM_SRC-1:0] fifo_full_i,
  input  logic [NUM_SRC-1:0] fifo_empty_i,
  input  logic               sw_wr_i,
  input  logic [STS_W-1:0]   sw_wdata_i,
  output logic [STS_W-1:0]   err_code_o,
  output logic               irq_fifo_err_o
);
  // NUM_SRC must stay at or below KIND_LSB so sources and types do not overlap.
  localparam logic [STS_W-1:0] SRC_MASK  = {{(STS_W-NUM_SRC){1'b0}}, {NUM_SRC{1'b1}}};
  localparam logic [STS_W-1:0] KIND_MASK =
    {{(STS_W-NUM_KINDS){1'b0}}, {NUM_KINDS{1'b1}}} << KIND_LSB;
  localparam logic [STS_W-1:0] RSVD_MASK = ~(SRC_MASK | KIND_MASK);

  logic [NUM_SRC-1:0]   src_hit;
  logic [NUM_KINDS-1:0] kind_hit;
  logic [NUM_SRC-1:0]   src_q;
  logic [NUM_KINDS-1:0] kind_q;
  logic                 unused_wdata;

  assign unused_wdata = ^(sw_wdata_i & RSVD_MASK);

  fifo_fault_detect #(.NUM_SRC(NUM_SRC)) u_detect (
    .wr_i      (fifo_wr_i),
    .rd_i      (fifo_rd_i),
    .full_i    (fifo_full_i),
    .empty_i   (fifo_empty_i),
    .src_hit_o (src_hit),
    .kind_hit_o(kind_hit)
  );

  fault_sticky_bank #(.WIDTH(NUM_SRC)) u_src_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (src_hit),
    .clr_en_i(sw_wr_i),
    .keep_i  (sw_wdata_i[NUM_SRC-1:0]),
    .q_o     (src_q)
  );

  fault_sticky_bank #(.WIDTH(NUM_KINDS)) u_kind_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (kind_hit),
    .clr_en_i(sw_wr_i),
    .keep_i  (sw_wdata_i[KIND_LSB +: NUM_KINDS]),
    .q_o     (kind_q)
  );

  always_comb begin
    err_code_o                        = '0;
    err_code_o[NUM_SRC-1:0]           = src_q;
    err_code_o[KIND_LSB +: NUM_KINDS] = kind_q;
  end

  assign irq_fifo_err_o = |src_q;

  // R2: write into a full FIFO flags the write-when-full type
  assert_wr_full_type_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(fifo_wr_i & fifo_full_i)) |=> err_code_o[KIND_LSB + int'(KIND_WR_FULL)]);

  // R3: read from an empty FIFO flags the read-when-empty type
  assert_rd_empty_type_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(fifo_rd_i & fifo_empty_i)) |=> err_code_o[KIND_LSB + int'(KIND_RD_EMPTY)]);

  // R4: full and empty together flags the state type
  assert_full_empty_type_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(fifo_full_i & fifo_empty_i)) |=> err_code_o[KIND_LSB + int'(KIND_FULL_EMPTY)]);

  // R5: without faults or writes the word does not move
  assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr_i && src_hit == '0) |=> $stable(err_code_o));

  // R6: no bit drops without a software write
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr_i |=> (($past(err_code_o) & ~err_code_o) == '0));

  // R9: every faulting source shows up
  assert_all_sources_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_hit) |=> ((err_code_o[NUM_SRC-1:0] & $past(src_hit)) == $past(src_hit)));

  // R10: reserved bits read zero
  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code_o & RSVD_MASK) == '0);

  // R11: a fault raises the interrupt on the next clock
  assert_irq_raise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_hit) |=> irq_fifo_err_o);
endmodule

// File: tb/tb_fifo_fault_status.sv
`timescale 1ns/1ps
module tb_fifo_fault_status;
  localparam int unsigned N = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  fifo_wr, fifo_rd, fifo_full, fifo_empty;
  logic          sw_wr;
  logic [31:0]   sw_wdata;
  logic [31:0]   err_code;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  fifo_fault_status dut (
    .clk(clk), .rst_n(rst_n),
    .fifo_wr_i(fifo_wr), .fifo_rd_i(fifo_rd),
    .fifo_full_i(fifo_full), .fifo_empty_i(fifo_empty),
    .sw_wr_i(sw_wr), .sw_wdata_i(sw_wdata),
    .err_code_o(err_code), .irq_fifo_err_o(irq)
  );

  localparam logic [31:0] T_WR = 32'h1000_0000; // bit 28
  localparam logic [31:0] T_RD = 32'h2000_0000; // bit 29
  localparam logic [31:0] T_ST = 32'h4000_0000; // bit 30

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic quiet();
    fifo_wr = '0; fifo_rd = '0; fifo_full = '0; fifo_empty = '0;
    sw_wr = 1'b0; sw_wdata = '0;
  endtask

  // inputs set at a falling edge, removed at the next; one rising edge between
  task automatic one_cycle();
    @(negedge clk);
    quiet();
  endtask

  task automatic sw_write(input logic [31:0] d);
    @(negedge clk);
    sw_wr = 1'b1; sw_wdata = d;
    one_cycle();
  endtask

  task automatic t_reset();
    chk("R1 word", err_code, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_overflow();
    @(negedge clk);
    fifo_wr[3] = 1'b1; fifo_full[3] = 1'b1;
    one_cycle();
    chk("R2 word", err_code, 32'h8 | T_WR);
    chk("R11 irq rise", {31'b0, irq}, 32'h1);
    repeat (3) @(negedge clk);
    chk("R6 held", err_code, 32'h8 | T_WR);
    sw_write(32'h0);
    chk("R7 clear all", err_code, 32'h0);
    chk("R11 irq fall", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_underflow();
    @(negedge clk);
    fifo_rd[15] = 1'b1; fifo_empty[15] = 1'b1;
    one_cycle();
    chk("R3 word", err_code, 32'h8000 | T_RD);
    chk("R10 reserved", err_code & 32'h8FFF_0000, 32'h0);
    sw_write(32'h0);
  endtask

  task automatic t_state();
    @(negedge clk);
    fifo_full[0] = 1'b1; fifo_empty[0] = 1'b1;
    one_cycle();
    chk("R4 word", err_code, 32'h1 | T_ST);
    sw_write(32'h0);
    chk("R4 cleared", err_code, 32'h0);
  endtask

  task automatic t_legal();
    @(negedge clk);
    fifo_wr = 16'hFFFF; fifo_rd = 16'hFFFF;
    @(negedge clk);
    fifo_wr = '0; fifo_rd = '0; fifo_full = 16'h00FF; fifo_empty = 16'hFF00;
    @(negedge clk);
    fifo_wr = 16'hFF00; fifo_rd = 16'h00FF;
    one_cycle();
    chk("R5 no fault", err_code, 32'h0);
    chk("R5 irq low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_partial_clear();
    @(negedge clk);
    fifo_wr[2] = 1'b1; fifo_full[2] = 1'b1;
    fifo_rd[7] = 1'b1; fifo_empty[7] = 1'b1;
    one_cycle();
    chk("R2 R3 both", err_code, 32'h84 | T_WR | T_RD);
    sw_write(32'h80 | T_RD);
    chk("R7 partial", err_code, 32'h80 | T_RD);
  endtask

  task automatic t_set_wins();
    // word holds bit7|bit29; clear all while FIFO 7 overflows
    @(negedge clk);
    sw_wr = 1'b1; sw_wdata = 32'h0;
    fifo_wr[7] = 1'b1; fifo_full[7] = 1'b1;
    one_cycle();
    chk("R8 set wins", err_code, 32'h80 | T_WR);
    sw_write(32'h0);
  endtask

  task automatic t_multi();
    @(negedge clk);
    fifo_wr[1] = 1'b1; fifo_full[1] = 1'b1;
    fifo_rd[9] = 1'b1; fifo_empty[9] = 1'b1;
    fifo_full[12] = 1'b1; fifo_empty[12] = 1'b1;
    one_cycle();
    chk("R9 multi", err_code, 32'h1202 | T_WR | T_RD | T_ST);
    sw_write(32'hFFFF_FFFF);
    chk("R10 ones kept", err_code, 32'h1202 | T_WR | T_RD | T_ST);
    chk("R11 irq level", {31'b0, irq}, 32'h1);
    sw_write(32'h0);
    chk("R7 final", err_code, 32'h0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    quiet();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_overflow();
    t_underflow();
    t_state();
    t_legal();
    t_partial_clear();
    t_set_wins();
    t_multi();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule